// File: doc/BRIEF.md
# Prioritized Interrupt Source Controller

This block collects one-cycle event pulses from seven interrupt sources: a wake-up from stop, high-side driver over-temperature, low-side driver over-temperature, a LIN fault or LIN wake-up, a low-voltage group (supply under-voltage or regulator over-temperature prewarning), a supply over-voltage, and a forced wake-up. Each event sets a sticky pending flag. The flags are grouped into five reportable codes. The highest-priority pending code is shown in a source register.

A host reads the source register through a simple strobe interface. Each read acknowledges only the code that the read returns. A four-bit enable register is written through the same interface. It decides which flags can pull the active-low request line `irq_n`. A flag that is disabled still latches and is still reported in the source register.

When a read leaves enabled work still pending, the request line is released high for a fixed window of `CLK_PER_US * RELEASE_US` clock cycles. After the window it is driven low again, so the host sees a fresh falling edge for every queued source.

Top module: `irq_source_ctrl`

## Requirements
- R1: A one-cycle pulse on bit i of `evt` sets pending flag i. The flag stays set until a read acknowledges its code. The bit order is 0 wake-up, 1 high-side over-temperature, 2 low-side over-temperature, 3 LIN, 4 low-voltage, 5 over-voltage, 6 forced wake-up.
- R2: A write (`wr_en`) loads `wr_data` into the enable register. Bit 3 enables high-side, bit 2 low-side, bit 1 LIN and bit 0 over-voltage, and 1 means enabled. Reset sets all four bits to 1.
- R3: A source whose enable bit is 0 still sets its flag and is still reported in the source register, but it never pulls `irq_n` low.
- R4: The wake-up, low-voltage and forced wake-up sources cannot be disabled. Within the voltage group, only the over-voltage source is gated by enable bit 0.
- R5: The source codes are 0 for none, 1 for wake-up, 3 for high-side or low-side over-temperature, 4 for LIN, 5 for low-voltage or over-voltage, and 6 for forced wake-up.
- R6: With several codes pending, the register shows the numerically lowest nonzero code, so 1 is highest priority and 6 is lowest.
- R7: On the cycle after `rd_en` or `wr_en`, `rd_data` holds the code that was shown at the strobe. A read clears every flag belonging to that code. A write clears nothing.
- R8: If a read leaves no enabled flag pending, `irq_n` is high on the following cycle and stays high.
- R9: If a read leaves an enabled flag pending, `irq_n` is high for exactly `CLK_PER_US*RELEASE_US` cycles and then goes low. Reads made inside the window neither shorten it nor restart it.
- R10: If an event for a source arrives in the same cycle as the read that clears that source, the flag stays set.
- R11: After reset, `irq_n` is 1 and `rd_data` is 0. Outside a release window, `irq_n` is low exactly when some enabled flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 7 | One-cycle event pulses, one bit per source |
| rd_en | input | 1 | Read strobe for the source register (acknowledges) |
| wr_en | input | 1 | Write strobe for the enable register |
| wr_data | input | 4 | Enable bits for the write |
| rd_data | output | 4 | Source code captured at the last strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest situation to reach is a second acknowledge that lands inside a release window while a third source is still queued. That case shows whether the window is restarted, cut short or left alone. The stimulus raises three enabled sources in different priority groups, reads once, and reads again a few cycles into the window. It then checks `irq_n` one cycle before and exactly at the programmed window length. A second corner case is an event that coincides with its own acknowledge. It is driven by raising the event and the read strobe on the same edge.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

    localparam int NSRC = 7;

    typedef enum int unsigned {
        SRC_WAKE  = 0,
        SRC_HS    = 1,
        SRC_LS    = 2,
        SRC_LIN   = 3,
        SRC_VLOW  = 4,
        SRC_VHIGH = 5,
        SRC_FWAKE = 6
    } src_e;

    typedef enum logic [3:0] {
        CODE_NONE   = 4'h0,
        CODE_WAKE   = 4'h1,
        CODE_DRV_OT = 4'h3,
        CODE_LIN    = 4'h4,
        CODE_VMON   = 4'h5,
        CODE_FWAKE  = 4'h6
    } code_e;

    // packed so that hs lands in bit 3 and vmon in bit 0
    typedef struct packed {
        logic hs;
        logic ls;
        logic lin;
        logic vmon;
    } enable_t;

    function automatic code_e code_of(input int unsigned idx);
        case (idx)
            SRC_WAKE:            return CODE_WAKE;
            SRC_HS, SRC_LS:      return CODE_DRV_OT;
            SRC_LIN:             return CODE_LIN;
            SRC_VLOW, SRC_VHIGH: return CODE_VMON;
            SRC_FWAKE:           return CODE_FWAKE;
            default:             return CODE_NONE;
        endcase
    endfunction

    function automatic logic [NSRC-1:0] enables_of(input enable_t en);
        logic [NSRC-1:0] v;
        v            = '1;
        v[SRC_HS]    = en.hs;
        v[SRC_LS]    = en.ls;
        v[SRC_LIN]   = en.lin;
        v[SRC_VHIGH] = en.vmon;
        return v;
    endfunction

endpackage

// File: rtl/irqsrc_flags.sv
module irqsrc_flags
    import irqsrc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         ack,
    input  code_e        shown,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] flags_nxt
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr;
        assign clr          = ack && (code_of(i) == shown);
        assign flags_nxt[i] = evt[i] | (flags_q[i] & ~clr);

        always_ff @(posedge clk) begin
            if (rst) flags_q[i] <= 1'b0;
            else     flags_q[i] <= flags_nxt[i];
        end
    end
endmodule

// File: rtl/irqsrc_prio.sv
module irqsrc_prio
    import irqsrc_pkg::*;
(
    input  logic [NSRC-1:0] flags,
    output code_e           code
);
    always_comb begin
        if (flags[SRC_WAKE])                         code = CODE_WAKE;
        else if (flags[SRC_HS] || flags[SRC_LS])     code = CODE_DRV_OT;
        else if (flags[SRC_LIN])                     code = CODE_LIN;
        else if (flags[SRC_VLOW] || flags[SRC_VHIGH]) code = CODE_VMON;
        else if (flags[SRC_FWAKE])                   code = CODE_FWAKE;
        else                                         code = CODE_NONE;
    end
endmodule

// File: rtl/irqsrc_window.sv
module irqsrc_window #(
    parameter int HOLD = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
        else if (start)            cnt_q <= LOAD;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
    import irqsrc_pkg::*;
#(
    parameter int CLK_PER_US = 4,
    parameter int RELEASE_US = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [3:0]      wr_data,
    output logic [3:0]      rd_data,
    output logic            irq_n
);
    localparam int HOLD = CLK_PER_US * RELEASE_US;

    enable_t         en_q;
    logic [NSRC-1:0] flags_q, flags_nxt, en_vec;
    code_e           code;
    logic            win_active, win_start, ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '1;
            rd_data <= '0;
        end else begin
            if (wr_en) en_q <= enable_t'(wr_data);
            if (rd_en || wr_en) rd_data <= code;
        end
    end

    assign ack    = rd_en && (code != CODE_NONE);
    assign en_vec = enables_of(en_q);

    irqsrc_flags #(.N(NSRC)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .ack       (ack),
        .shown     (code),
        .flags_q   (flags_q),
        .flags_nxt (flags_nxt)
    );

    irqsrc_prio u_prio (
        .flags (flags_q),
        .code  (code)
    );

    assign win_start = ack && |(flags_nxt & enables_of(wr_en ? enable_t'(wr_data) : en_q));

    irqsrc_window #(.HOLD(HOLD)) u_win (
        .clk    (clk),
        .rst    (rst),
        .start  (win_start),
        .active (win_active)
    );

    assign irq_n = ~(|(flags_q & en_vec) && !win_active);
endmodule

// File: rtl/irqsrc_checker.sv
module irqsrc_checker
    import irqsrc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] evt,
    input logic            rd_en,
    input logic            wr_en,
    input logic [3:0]      rd_data,
    input logic            irq_n,
    input logic [3:0]      en_bits,
    input logic [NSRC-1:0] flags,
    input logic [NSRC-1:0] en_vec,
    input logic [3:0]      code,
    input logic            win_active
);
    // R1: an event pulse is latched on the next cycle
    assert_evt_latched_R1: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    // R2: enable bits come out of reset all set
    assert_enable_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_bits == 4'hF));

    // R3: a low request needs an enabled pending flag
    assert_req_needs_enabled_R3: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> |(flags & en_vec));

    // R7: a strobe captures the code that was shown
    assert_strobe_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |=> (rd_data == $past(code)));

    // R7: a quiet read moves the shown code on
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && code != 4'h0 && evt == '0) |=> (code != $past(code)));

    // R9: the request stays released during the window
    assert_window_high_R9: assert property (@(posedge clk) disable iff (rst)
        win_active |-> irq_n);

    // R11: nothing pending means no request
    assert_idle_high_R11: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> irq_n);
endmodule

bind irq_source_ctrl irqsrc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .irq_n      (irq_n),
    .en_bits    (en_q),
    .flags      (flags_q),
    .en_vec     (en_vec),
    .code       (code),
    .win_active (win_active)
);

// File: tb/tb_irq_source_ctrl.sv
module tb_irq_source_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CPU  = 4;
    localparam int RUS  = 10;
    localparam int HOLD = CPU * RUS;
    localparam int NV   = 12;
    // each row: {event bits 6..0, expected code of the following read}
    localparam logic [10:0] VEC [NV] = '{
        11'b0000001_0001, 11'b1000000_0110, 11'b0001000_0100,
        11'b1001010_0011, 11'b0000000_0100, 11'b0000000_0110,
        11'b0110000_0101, 11'b0000000_0000, 11'b0000100_0011,
        11'b0100001_0001, 11'b0000000_0101, 11'b0000000_0000
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] evt = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_data;
    logic       irq_n;
    int n_chk = 0, n_bad = 0;
    logic [3:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_source_ctrl #(.CLK_PER_US(CPU), .RELEASE_US(RUS)) dut (
        .clk(clk), .rst(rst), .evt(evt), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk) evt = e;
        @(negedge clk) evt = '0;
    endtask

    task automatic do_read(output logic [3:0] r);
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        r = rd_data;
    endtask

    task automatic do_write(input logic [3:0] d, output logic [3:0] r);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
        r = rd_data;
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset irq_n", {3'b0, irq_n}, 4'h1);
        check("R11 reset rd_data", rd_data, 4'h0);
        pulse(7'b0000010);
        check("R2 reset enables high-side", {3'b0, irq_n}, 4'h0);
        do_read(v);
        check("R5 high-side code", v, 4'h3);
        check("R8 release when empty", {3'b0, irq_n}, 4'h1);

        // table walk: codes and priority
        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][10:4]);
            do_read(v);
            check($sformatf("R6 row %0d", i), v, VEC[i][3:0]);
        end
        repeat (HOLD + 2) @(negedge clk);

        // disabled source still latched and reported
        do_write(4'h0, v);
        check("R7 write returns empty code", v, 4'h0);
        pulse(7'b0000010);
        check("R3 disabled high-side no request", {3'b0, irq_n}, 4'h1);
        do_write(4'h0, v);
        check("R7 write returns pending code", v, 4'h3);
        do_read(v);
        check("R3 disabled source reported", v, 4'h3);

        // unmaskable sources
        pulse(7'b0100000);
        check("R4 over-voltage gated", {3'b0, irq_n}, 4'h1);
        pulse(7'b0010000);
        check("R4 low-voltage not gated", {3'b0, irq_n}, 4'h0);
        do_read(v);
        check("R4 voltage code", v, 4'h5);
        check("R4 voltage group cleared", {3'b0, irq_n}, 4'h1);
        pulse(7'b1000000);
        check("R4 forced wake not gated", {3'b0, irq_n}, 4'h0);
        do_read(v);
        check("R5 forced wake code", v, 4'h6);
        pulse(7'b0000001);
        check("R4 wake not gated", {3'b0, irq_n}, 4'h0);
        do_read(v);
        check("R5 wake code", v, 4'h1);

        // release window with a read inside it
        do_write(4'hF, v);
        pulse(7'b1001010);
        check("R11 enabled pending drives low", {3'b0, irq_n}, 4'h0);
        do_read(v);
        check("R9 first read code", v, 4'h3);
        check("R9 window starts high", {3'b0, irq_n}, 4'h1);
        repeat (5) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        check("R9 read inside window", rd_data, 4'h4);
        repeat (HOLD - 1 - 6) @(negedge clk);
        check("R9 still high at HOLD-1", {3'b0, irq_n}, 4'h1);
        @(negedge clk);
        check("R9 low again at HOLD", {3'b0, irq_n}, 4'h0);
        do_read(v);
        check("R7 last queued code", v, 4'h6);
        check("R8 empty after last read", {3'b0, irq_n}, 4'h1);
        repeat (HOLD + 2) @(negedge clk);
        check("R8 stays high", {3'b0, irq_n}, 4'h1);

        // event coincides with its own acknowledge
        pulse(7'b0000010);
        @(negedge clk) begin evt = 7'b0000010; rd_en = 1'b1; end
        @(negedge clk) begin evt = '0; rd_en = 1'b0; end
        check("R10 read code", rd_data, 4'h3);
        do_read(v);
        check("R10 event wins over clear", v, 4'h3);
        do_read(v);
        check("R1 flag cleared afterwards", v, 4'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule